// File: doc/BRIEF.md
# Serial Nibble Register Access Master

This block is the host side of a three-wire serial link to a clock chip whose registers each hold four bits. The link has a select line, a clock line and one shared data line. A caller gives a request with a 4-bit register address, a write flag and a 4-bit write value. The block turns the request into command bytes, shifts them out one bit at a time with the most significant bit first, and then either sends a data byte or turns the data line around and clocks in the reply. It finishes with a one-cycle done pulse. For reads, the low nibble of the reply is placed on the result port.

The select line is copied from a caller input through one register. This lets a caller keep the chip selected across several accesses. Bit timing comes from a half-period parameter given in system clock cycles, so the same block can match a slow device from any fast core clock. The shared data line is split into separate out, out-enable and in signals. Any tri-state pad sits outside the block.

Top module: `nib3w_master`

## Requirements
- R1: After reset and whenever no request is in progress, sck_o is high, sd_oe_o is low, ce_o is low until ce_i is raised, and done_o and busy_o are low.
- R2: Every byte is sent as exactly 8 serial clocks with the most significant bit first. sd_o holds its value for the whole low phase of sck_o. A read and a write each take exactly 16 falling edges of sck_o.
- R3: Every low phase of sck_o lasts exactly HALF_CYC system clock cycles, and the high phase before each falling edge of a byte also lasts HALF_CYC cycles.
- R4: A read starts with the command byte 0x60 OR address. Bit 6 flags a read, bit 5 flags the address phase, and bits 3:0 carry the address.
- R5: After the read command, sd_oe_o stays low for 8 more serial clocks. sd_i is sampled just before each falling edge of sck_o, most significant bit first. rdata_o gets the low 4 bits of the received byte, and the upper 4 bits are ignored.
- R6: A write sends the byte 0x20 OR address, then the byte 0x10 OR value. Bit 4 flags the data phase, and bits 3:0 carry the value.
- R7: sd_oe_o is high on every falling edge of a byte the block transmits, and it goes low after that byte's eighth bit.
- R8: Each accepted request produces exactly one done_o pulse, one cycle wide, while req_i is held.
- R9: Once a request is accepted, changes on req_i, we_i, addr_i and wdata_i have no effect until done_o. The bytes on the wire carry the values held at acceptance.
- R10: ce_o follows ce_i with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request; held with its fields until done_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register address |
| wdata_i | input | 4 | Write value |
| ce_i | input | 1 | Caller's chip-select level |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Access in progress |
| rdata_o | output | 4 | Nibble returned by the last read |
| ce_o | output | 1 | Chip select to the device |
| sck_o | output | 1 | Serial clock, rests high |
| sd_o | output | 1 | Serial data out |
| sd_oe_o | output | 1 | Serial data output enable |
| sd_i | input | 1 | Serial data in |

## Verification
The assertions watch, on every cycle, the resting state of the clock and the output enable while idle. They also check that data holds steady while the clock is low, that the output enable is never raised during a read's reply byte, and that done is one cycle wide. The exact byte contents, the bit order, the low-phase length, the masking of the reply's upper nibble and the immunity to field changes during an access can only be shown by the bench. Its device model captures the wire and answers reads from every address.

// File: rtl/nib3w_pkg.sv
package nib3w_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_RD = 8'h40;
  localparam logic [BYTE_W-1:0] CMD_AD = 8'h20;
  localparam logic [BYTE_W-1:0] CMD_DT = 8'h10;

  typedef enum logic [1:0] {T_IDLE, T_CMD, T_SEC, T_FIN} top_st_e;
  typedef enum logic [1:0] {SH_IDLE, SH_HI, SH_LO} sh_st_e;
endpackage

// File: rtl/nib3w_halfper.sv
module nib3w_halfper #(
  parameter int HALF_CYC = 70
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (restart_i)        cnt_q <= CW'(HALF_CYC - 1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = (cnt_q == '0);
endmodule

// File: rtl/nib3w_shifter.sv
module nib3w_shifter
  import nib3w_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tx_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              tick_i,
  input  logic              sd_i,
  output logic              restart_o,
  output logic              done_o,
  output logic              sck_o,
  output logic              sd_o,
  output logic              sd_oe_o,
  output logic [NIB_W-1:0]  rx_o
);
  localparam int BC_W = $clog2(BYTE_W);

  sh_st_e            st_q;
  logic [BYTE_W-1:0] sreg_q;
  logic [BC_W-1:0]   bcnt_q;
  logic              tx_q, sck_q, sd_q, oe_q;
  logic              last_bit;

  assign last_bit = (bcnt_q == BC_W'(BYTE_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SH_IDLE; sreg_q <= '0; bcnt_q <= '0;
      tx_q <= 1'b0; sck_q <= 1'b1; sd_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      unique case (st_q)
        SH_IDLE: if (start_i) begin
          st_q   <= SH_HI;
          sreg_q <= byte_i;
          bcnt_q <= '0;
          tx_q   <= tx_i;
          sd_q   <= tx_i & byte_i[BYTE_W-1];
          oe_q   <= tx_i;
        end
        SH_HI: if (tick_i) begin
          // receive: sample before the falling edge
          if (!tx_q) sreg_q <= {sreg_q[BYTE_W-2:0], sd_i};
          sck_q <= 1'b0;
          st_q  <= SH_LO;
        end
        SH_LO: if (tick_i) begin
          sck_q <= 1'b1;
          if (last_bit) begin
            st_q <= SH_IDLE;
            oe_q <= 1'b0;
            sd_q <= 1'b0;
          end else begin
            st_q   <= SH_HI;
            bcnt_q <= bcnt_q + 1'b1;
            if (tx_q) begin
              sreg_q <= {sreg_q[BYTE_W-2:0], 1'b0};
              sd_q   <= sreg_q[BYTE_W-2];
            end
          end
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  assign restart_o = (st_q == SH_IDLE) ? start_i : tick_i;
  assign done_o    = (st_q == SH_LO) && tick_i && last_bit;
  assign sck_o     = sck_q;
  assign sd_o      = sd_q;
  assign sd_oe_o   = oe_q;
  assign rx_o      = sreg_q[NIB_W-1:0];

  a_r2_sd_stable_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_q && $past(!sck_q)) |-> $stable(sd_q));
endmodule

// File: rtl/nib3w_master.sv
module nib3w_master
  import nib3w_pkg::*;
#(
  parameter int HALF_CYC = 70
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [NIB_W-1:0] addr_i,
  input  logic [NIB_W-1:0] wdata_i,
  input  logic             ce_i,
  output logic             done_o,
  output logic             busy_o,
  output logic [NIB_W-1:0] rdata_o,
  output logic             ce_o,
  output logic             sck_o,
  output logic             sd_o,
  output logic             sd_oe_o,
  input  logic             sd_i
);
  top_st_e           st_q;
  logic              wr_q, start_q, ce_q;
  logic [NIB_W-1:0]  addr_q, wdata_q, rdata_q;
  logic              sh_tx, sh_restart, sh_tick, sh_done;
  logic [BYTE_W-1:0] sh_byte, cmd_byte;
  logic [NIB_W-1:0]  sh_rx;

  assign cmd_byte = CMD_AD | (wr_q ? '0 : CMD_RD) | BYTE_W'(addr_q);
  assign sh_byte  = (st_q == T_CMD) ? cmd_byte : (CMD_DT | BYTE_W'(wdata_q));
  assign sh_tx    = (st_q == T_CMD) || wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= T_IDLE; wr_q <= 1'b0; start_q <= 1'b0; ce_q <= 1'b0;
      addr_q <= '0; wdata_q <= '0; rdata_q <= '0;
    end else begin
      ce_q    <= ce_i;
      start_q <= 1'b0;
      unique case (st_q)
        T_IDLE: if (req_i) begin
          st_q <= T_CMD; start_q <= 1'b1;
          wr_q <= we_i; addr_q <= addr_i; wdata_q <= wdata_i;
        end
        T_CMD: if (sh_done) begin
          st_q <= T_SEC; start_q <= 1'b1;
        end
        T_SEC: if (sh_done) begin
          st_q <= T_FIN;
          if (!wr_q) rdata_q <= sh_rx;
        end
        T_FIN:   st_q <= T_IDLE;
        default: st_q <= T_IDLE;
      endcase
    end
  end

  nib3w_halfper #(.HALF_CYC(HALF_CYC)) u_halfper (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(sh_restart), .tick_o(sh_tick)
  );

  nib3w_shifter u_shifter (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_q), .tx_i(sh_tx),
    .byte_i(sh_byte), .tick_i(sh_tick), .sd_i(sd_i), .restart_o(sh_restart),
    .done_o(sh_done), .sck_o(sck_o), .sd_o(sd_o), .sd_oe_o(sd_oe_o), .rx_o(sh_rx)
  );

  assign done_o  = (st_q == T_FIN);
  assign busy_o  = (st_q != T_IDLE);
  assign rdata_o = rdata_q;
  assign ce_o    = ce_q;

  a_r1_idle_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == T_IDLE) |-> (sck_o && !sd_oe_o));
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_oe_tx_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_oe_o |-> ((st_q == T_CMD) || wr_q));
  a_r5_rx_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == T_SEC) && !wr_q) |-> !sd_oe_o);
endmodule

// File: tb/tb_nib3w_master.sv
module tb_nib3w_master;
  localparam int HALF = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 0, we_i = 0, ce_i = 0, sd_i = 0;
  logic [3:0] addr_i = 0, wdata_i = 0;
  logic done_o, busy_o, ce_o, sck_o, sd_o, sd_oe_o;
  logic [3:0] rdata_o;

  always #5 clk = ~clk;

  nib3w_master #(.HALF_CYC(HALF)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .ce_i(ce_i), .done_o(done_o), .busy_o(busy_o),
    .rdata_o(rdata_o), .ce_o(ce_o), .sck_o(sck_o), .sd_o(sd_o),
    .sd_oe_o(sd_oe_o), .sd_i(sd_i)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  // device model
  logic [3:0] dev_mem [16];
  logic [7:0] cmd_cap, sec_cap;
  int fall_cnt, low_cnt;
  bit is_rd, oe_bad, low_bad, prev_sck;
  logic [7:0] resp;

  initial begin
    for (int i = 0; i < 16; i++) dev_mem[i] = 4'h0;
    prev_sck = 1; fall_cnt = 0; low_cnt = 0; is_rd = 0; oe_bad = 0; low_bad = 0;
    cmd_cap = 0; sec_cap = 0; resp = 0;
  end

  always @(negedge clk) begin
    if (!busy_o) begin
      fall_cnt = 0; low_cnt = 0; is_rd = 0; oe_bad = 0; low_bad = 0;
      cmd_cap = 0; sec_cap = 0; sd_i = 0;
    end else begin
      if (!sck_o) low_cnt++;
      if (prev_sck && !sck_o) begin
        if (fall_cnt < 8) begin
          cmd_cap = {cmd_cap[6:0], sd_o};
          if (!sd_oe_o) oe_bad = 1;
        end else if (is_rd) begin
          if (sd_oe_o) oe_bad = 1;
        end else begin
          sec_cap = {sec_cap[6:0], sd_o};
          if (!sd_oe_o) oe_bad = 1;
        end
        fall_cnt++;
        if (fall_cnt == 8) begin
          is_rd = cmd_cap[6];
          resp  = {~cmd_cap[3:0], dev_mem[cmd_cap[3:0]]};
        end
        if (fall_cnt == 16 && !is_rd) dev_mem[cmd_cap[3:0]] = sec_cap[3:0];
      end
      if (!prev_sck && sck_o) begin
        if (low_cnt != HALF) low_bad = 1;
        low_cnt = 0;
        if (is_rd && fall_cnt >= 8 && fall_cnt < 16) sd_i = resp[15-fall_cnt];
      end
    end
    prev_sck = sck_o;
  end

  logic [3:0] exp_mem [16];

  task automatic access(input logic we, input logic [3:0] a, input logic [3:0] d);
    int n;
    @(negedge clk);
    we_i = we; addr_i = a; wdata_i = d; req_i = 1;
    repeat (3) @(negedge clk);
    // R9: scramble fields while busy
    we_i = ~we; addr_i = ~a; wdata_i = ~d;
    n = 0;
    while (!done_o && n < 2000) begin @(negedge clk); n++; end
    chk(done_o, "R8 done seen", int'(done_o), 1);
    chk(fall_cnt == 16, "R2 sixteen clocks", fall_cnt, 16);
    chk(!low_bad, "R3 low phase length", int'(low_bad), 0);
    chk(!oe_bad, "R7 output enable", int'(oe_bad), 0);
    if (we) begin
      chk(cmd_cap == (8'h20 | {4'h0, a}), "R6 write cmd R9", cmd_cap, 8'h20 | a);
      chk(sec_cap == (8'h10 | {4'h0, d}), "R6 write data R9", sec_cap, 8'h10 | d);
      exp_mem[a] = d;
    end else begin
      chk(cmd_cap == (8'h60 | {4'h0, a}), "R4 read cmd R9", cmd_cap, 8'h60 | a);
      chk(rdata_o == exp_mem[a], "R5 read nibble", rdata_o, exp_mem[a]);
    end
    req_i = 0;
    @(negedge clk);
    chk(!done_o, "R8 done one cycle", int'(done_o), 0);
    chk(sck_o && !sd_oe_o, "R1 idle lines", {sck_o, sd_oe_o}, 2'b10);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) exp_mem[i] = 4'h0;
    repeat (3) @(negedge clk);
    chk(sck_o == 1'b1, "R1 reset sck", sck_o, 1);
    chk(ce_o == 1'b0 && !sd_oe_o, "R1 reset ce/oe", {ce_o, sd_oe_o}, 0);
    chk(!done_o && !busy_o, "R1 reset done/busy", {done_o, busy_o}, 0);
    rst_ni = 1;
    @(negedge clk);
    ce_i = 1;
    chk(ce_o == 1'b0, "R10 ce delay", ce_o, 0);
    @(negedge clk);
    chk(ce_o == 1'b1, "R10 ce follows", ce_o, 1);
    for (int a = 0; a < 16; a++) access(1'b1, 4'(a), 4'((a * 7 + 3) & 15));
    for (int a = 0; a < 16; a++) access(1'b0, 4'(a), 4'h0);
    for (int a = 15; a >= 0; a--) access(1'b1, 4'(a), 4'((a * 5 + 9) & 15));
    for (int a = 15; a >= 0; a--) access(1'b0, 4'(a), 4'hF);
    ce_i = 0;
    @(negedge clk); @(negedge clk);
    chk(ce_o == 1'b0, "R10 ce release", ce_o, 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule